// File: doc/BRIEF.md
# Cycle Counter with Performance Monitor Control Word

This block holds the 32-bit control word of a performance monitor and the 64-bit cycle counter that the word governs. Software writes the word through a plain write strobe and data bus and reads it back on a combinational read bus. The upper half of the word is fixed at build time. It carries an implementer code, an identification code and the number of event counters present. The lower byte holds the writable controls and two strobe bits that clear counters when written.

The cycle counter advances when all three of these hold: the global enable is set, the counter's own enable input is high, and counting is not frozen by the prohibit input. It can step on every clock or once every 64 clocks. A sticky flag records overflow, either out of the low half of the counter or out of the full width, depending on the long-overflow control. Software drops the flag with a separate clear input. A few control bits are also driven out to the event counters, which live outside this block.

Top module: `pmu_cycle_monitor`

## Requirements
- R1: The read word is laid out as follows: bits 31:24 hold `IMPL_CODE`, bits 23:16 hold `ID_CODE`, bits 15:11 hold `NUM_CNT`, and bits 10:8 read zero. In the low byte, bit 7 is the long event mode, bit 6 is the long cycle overflow, bit 5 is freeze-when-prohibited, bit 4 is export, bit 3 is divide, bit 2 is the counter clear strobe, bit 1 is the event clear strobe and bit 0 is the enable. A write updates bits 7:3 and bit 0.
- R2: When `IMPL_CODE` is zero, bits 23:16 read zero.
- R3: After reset, every writable control bit is 0, the counter is 0 and the overflow flag is 0.
- R4: Bits 2 and 1 always read 0. Writing 1 to bit 2 zeroes the whole counter on that edge, even if an increment is due, and leaves the overflow flag unchanged.
- R5: The counter holds when the enable bit is 0 or when `cnt_en_i` is low. With divide=0 it otherwise adds 1 on every clock.
- R6: With divide=1 and long cycle overflow=0, the counter adds 1 once per 64 enabled clocks. The prescaler restarts on a clear-strobe write and on any write that changes the divide bit, so the first step lands on the 64th enabled clock after either event.
- R7: With long cycle overflow=1, the divide bit is ignored and the counter steps on every enabled clock.
- R8: With long cycle overflow=0, the flag sets on a carry out of the low `LOW_W` bits. With long cycle overflow=1, it sets only on a carry out of all `CNT_W` bits.
- R9: A pulse on `ovf_clr_i` drops the flag. If a flag-setting step and a clear arrive in the same cycle, the flag sets.
- R10: With freeze-when-prohibited=1, the counter holds while `prohibit_i` is high. With it at 0, `prohibit_i` has no effect on the counter.
- R11: `evt_enable_o` follows the enable bit and `evt_long_o` follows the long event bit. `evt_export_o` is the export bit gated low while `prohibit_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current control word |
| cnt_en_i | input | 1 | Enable bit for the cycle counter itself |
| prohibit_i | input | 1 | Event counting is not allowed |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| cyc_count_o | output | CNT_W | Cycle counter value |
| ovf_o | output | 1 | Sticky overflow flag |
| evt_enable_o | output | 1 | Enable bit toward the event counters |
| evt_long_o | output | 1 | Long event mode toward the event counters |
| evt_export_o | output | 1 | Event export permitted |

## Verification
A corrupted control bit shows on `rd_data_o` in the same cycle and changes the counting rate within one clock, or within 64 clocks in divided mode. A stale prescaler phase moves the first divided step away from the 64th clock after a restart, so the bench counts steps across exact 63- and 64-clock windows. A wrong overflow point shows on `ovf_o` at the exact increment that crosses the low-half or full-width boundary. For that reason the bench uses narrow counter widths, so it can reach both boundaries.

// File: rtl/pmu_cyc_pkg.sv
package pmu_cyc_pkg;
  localparam int BIT_E  = 0;
  localparam int BIT_P  = 1;
  localparam int BIT_C  = 2;
  localparam int BIT_D  = 3;
  localparam int BIT_X  = 4;
  localparam int BIT_DP = 5;
  localparam int BIT_LC = 6;
  localparam int BIT_LP = 7;

  typedef struct packed {
    logic lp;
    logic lc;
    logic dp;
    logic x;
    logic d;
    logic e;
  } pmu_ctl_t;
endpackage

// File: rtl/pmu_ctl_regs.sv
module pmu_ctl_regs
  import pmu_cyc_pkg::*;
#(
  parameter logic [7:0] IMPL_CODE = 8'h5A,
  parameter logic [7:0] ID_CODE   = 8'h13,
  parameter logic [4:0] NUM_CNT   = 5'd6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output pmu_ctl_t    ctl,
  output logic        cnt_zero,
  output logic        pre_clr,
  output logic [31:0] rd_word
);
  logic [7:0] id_field;
  logic       unused_wr;

  generate
    if (IMPL_CODE == 8'h00) begin : g_no_impl
      assign id_field = 8'h00;
    end else begin : g_impl
      assign id_field = ID_CODE;
    end
  endgenerate

  assign unused_wr = &{1'b0, wr_data[31:8], wr_data[BIT_P]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_en) begin
      ctl.lp <= wr_data[BIT_LP];
      ctl.lc <= wr_data[BIT_LC];
      ctl.dp <= wr_data[BIT_DP];
      ctl.x  <= wr_data[BIT_X];
      ctl.d  <= wr_data[BIT_D];
      ctl.e  <= wr_data[BIT_E];
    end
  end

  assign cnt_zero = wr_en & wr_data[BIT_C];
  assign pre_clr  = cnt_zero | (wr_en & (wr_data[BIT_D] != ctl.d));

  assign rd_word = {IMPL_CODE, id_field, NUM_CNT, 3'b000,
                    ctl.lp, ctl.lc, ctl.dp, ctl.x, ctl.d, 2'b00, ctl.e};

  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl.e == $past(wr_data[BIT_E])) && (ctl.d == $past(wr_data[BIT_D])));
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] phase;
  logic         at_last;

  assign at_last = (phase == LAST);
  assign tick    = adv & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (clr) begin
      phase <= '0;
    end else if (adv) begin
      phase <= at_last ? '0 : phase + W'(1);
    end
  end

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase == '0));
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(phase));
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
  parameter int CNT_W = 64,
  parameter int LOW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero,
  input  logic             inc,
  input  logic             long_mode,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic wrap_low;
  logic wrap_all;
  logic ovf_set;

  assign wrap_low = &count[LOW_W-1:0];
  assign wrap_all = &count;
  assign ovf_set  = inc & ~zero & (long_mode ? wrap_all : wrap_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (zero) begin
      count <= '0;
    end else if (inc) begin
      count <= count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
    end else if (ovf_set) begin
      ovf <= 1'b1;
    end else if (ovf_clr) begin
      ovf <= 1'b0;
    end
  end

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !zero |=> (count == $past(count)) || (count == $past(count) + CNT_W'(1)));
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/pmu_cycle_monitor.sv
module pmu_cycle_monitor
  import pmu_cyc_pkg::*;
#(
  parameter logic [7:0] IMPL_CODE = 8'h5A,
  parameter logic [7:0] ID_CODE   = 8'h13,
  parameter logic [4:0] NUM_CNT   = 5'd6,
  parameter int         CNT_W     = 64,
  parameter int         LOW_W     = 32,
  parameter int         DIV       = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  output logic [31:0]      rd_data_o,
  input  logic             cnt_en_i,
  input  logic             prohibit_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cyc_count_o,
  output logic             ovf_o,
  output logic             evt_enable_o,
  output logic             evt_long_o,
  output logic             evt_export_o
);
  pmu_ctl_t ctl;
  logic     cnt_zero;
  logic     pre_clr;
  logic     run;
  logic     divided;
  logic     tick;
  logic     inc;

  pmu_ctl_regs #(
    .IMPL_CODE(IMPL_CODE), .ID_CODE(ID_CODE), .NUM_CNT(NUM_CNT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_data(wr_data_i),
    .ctl(ctl), .cnt_zero(cnt_zero), .pre_clr(pre_clr), .rd_word(rd_data_o)
  );

  assign run     = ctl.e & cnt_en_i & ~(ctl.dp & prohibit_i);
  assign divided = ctl.d & ~ctl.lc;
  assign inc     = run & (divided ? tick : 1'b1);

  pmu_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(pre_clr), .adv(run & divided), .tick(tick)
  );

  pmu_cycle_counter #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .zero(cnt_zero), .inc(inc),
    .long_mode(ctl.lc), .ovf_clr(ovf_clr_i), .count(cyc_count_o), .ovf(ovf_o)
  );

  assign evt_enable_o = ctl.e;
  assign evt_long_o   = ctl.lp;
  assign evt_export_o = ctl.x & ~prohibit_i;

  assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[BIT_C]) |=> (cyc_count_o == '0));
  assert_clear_keeps_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[BIT_C] && ovf_o) |=> ovf_o);
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[BIT_DP] && prohibit_i && !(wr_en_i && wr_data_i[BIT_C])) |=> $stable(cyc_count_o));
  assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data_o[BIT_E] && !(wr_en_i && wr_data_i[BIT_C])) |=> $stable(cyc_count_o));
  assert_no_export_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prohibit_i |-> !evt_export_o);
endmodule

// File: tb/pmu_cycle_monitor_bench.sv
module pmu_cycle_monitor_bench;
  localparam logic [7:0] IMPL = 8'hA7;
  localparam logic [7:0] IDC  = 8'h3C;
  localparam logic [4:0] NCNT = 5'd6;
  localparam int CW = 16;
  localparam int LW = 8;
  localparam logic [23:0] HIGH = {IMPL, IDC, NCNT, 3'b000};

  localparam int NV = 7;
  localparam logic [39:0] VEC [NV] = '{
    {32'hFFFF_FFFF, 8'hF9}, {32'h0000_0006, 8'h00}, {32'h0000_0080, 8'h80},
    {32'h0000_0041, 8'h41}, {32'h0000_0028, 8'h28}, {32'h0000_0010, 8'h10},
    {32'h0000_0000, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic cnt_en = 1'b0;
  logic prohibit = 1'b0;
  logic ovf_clr = 1'b0;
  logic [31:0] rd_data, rd_b;
  logic [CW-1:0] count;
  logic [63:0] count_b;
  logic ovf, ovf_b, ev_en, ev_long, ev_exp, ev_en_b, ev_long_b, ev_exp_b;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pmu_cycle_monitor #(.IMPL_CODE(IMPL), .ID_CODE(IDC), .NUM_CNT(NCNT),
                      .CNT_W(CW), .LOW_W(LW), .DIV(64)) u_pmu_cycle_monitor (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .cnt_en_i(cnt_en), .prohibit_i(prohibit), .ovf_clr_i(ovf_clr),
    .cyc_count_o(count), .ovf_o(ovf), .evt_enable_o(ev_en),
    .evt_long_o(ev_long), .evt_export_o(ev_exp));

  pmu_cycle_monitor #(.IMPL_CODE(8'h00), .ID_CODE(IDC)) u_noimp (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_b),
    .cnt_en_i(cnt_en), .prohibit_i(prohibit), .ovf_clr_i(ovf_clr),
    .cyc_count_o(count_b), .ovf_o(ovf_b), .evt_enable_o(ev_en_b),
    .evt_long_o(ev_long_b), .evt_export_o(ev_exp_b));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic run(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic clr_flag();
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3 reset state, R1 fixed fields
    chk("R3 reset word", rd_data, {HIGH, 8'h00});
    chk("R3 reset count", count, 0);
    chk("R3 reset flag", ovf, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 table of writes and readback
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][39:8]);
      chk("R1 R4 readback", rd_data, {HIGH, VEC[i][7:0]});
    end
    chk("R4 no count while held", count, 0);
    // R2 identification zero when implementer zero
    chk("R2 id zero", rd_b[31:16], 16'h0000);

    // R11 control outputs
    wr(32'h0000_0091);
    chk("R11 enable out", ev_en, 1);
    chk("R11 long out", ev_long, 1);
    chk("R11 export allowed", ev_exp, 1);
    prohibit = 1'b1;
    #1;
    chk("R11 export gated", ev_exp, 0);
    prohibit = 1'b0;

    // R5 every clock
    wr(32'h0000_0005);
    run(37);
    chk("R5 every clock", count, 37);
    wr(32'h0000_0004);
    run(10);
    chk("R5 enable bit low holds", count, 0);
    wr(32'h0000_0001);
    repeat (10) @(negedge clk);
    chk("R5 own enable low holds", count, 0);

    // R4 clear beats increment
    cnt_en = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 counting", count, 5);
    wr(32'h0000_0005);
    chk("R4 clear priority", count, 0);
    cnt_en = 1'b0;

    // R6 divide by 64
    wr(32'h0000_000D);
    run(63);
    chk("R6 first window", count, 0);
    run(1);
    chk("R6 first tick", count, 1);
    run(128);
    chk("R6 two more", count, 3);
    run(10);
    wr(32'h0000_0001);
    run(5);
    chk("R6 undivided", count, 8);
    wr(32'h0000_0009);
    run(63);
    chk("R6 restart on divide change", count, 8);
    run(1);
    chk("R6 tick after change", count, 9);

    // R7 long overrides divide
    wr(32'h0000_004D);
    run(10);
    chk("R7 divide ignored", count, 10);

    // R8 low-half overflow, R4 clear keeps flag, R9
    wr(32'h0000_0005);
    run(255);
    chk("R8 before low carry", ovf, 0);
    run(1);
    chk("R8 low carry", ovf, 1);
    chk("R8 count past low", count, 256);
    wr(32'h0000_0005);
    chk("R4 flag kept", ovf, 1);
    chk("R4 count zeroed", count, 0);
    clr_flag();
    chk("R9 flag cleared", ovf, 0);
    run(255);
    cnt_en = 1'b1;
    ovf_clr = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0;
    ovf_clr = 1'b0;
    chk("R9 set beats clear", ovf, 1);
    clr_flag();

    // R8 full width
    wr(32'h0000_0045);
    run(65535);
    chk("R8 no flag at low carry in long mode", ovf, 0);
    chk("R8 count full", count, 16'hFFFF);
    run(1);
    chk("R8 full carry", ovf, 1);
    chk("R8 count wrapped", count, 0);
    clr_flag();

    // R10 freeze when prohibited
    prohibit = 1'b1;
    wr(32'h0000_0025);
    run(20);
    chk("R10 frozen", count, 0);
    wr(32'h0000_0005);
    run(20);
    chk("R10 prohibit ignored", count, 20);
    prohibit = 1'b0;

    // R3 reset mid-run
    wr(32'h0000_00F9);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R3 reset word again", rd_data, {HIGH, 8'h00});
    chk("R3 reset count again", count, 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule